// File: doc/BRIEF.md
# Handshaked Byte Receive Port

This block is a memory-mapped receive port that accepts 8-bit bytes from an outside producer over a valid/ready handshake and parks each one until software collects it. Software reaches it on a request/grant/response bus. A status word reports whether a byte is waiting and whether an interrupt is pending. A second word returns the waiting byte.

The port holds a single byte. After a byte lands, the port stops accepting until software acknowledges it. Software does this by writing a 1 to the waiting bit of the status word. Every capture also raises a pending-interrupt flag, which drives a level interrupt line. Software clears that flag on its own with a second write-one-to-clear bit.

The typical software loop is: poll the status word until the waiting bit is set, read the byte word, then write 1 to the status word to release the port.

Top module: `byte_rx_port`

## Requirements
- R1: After reset, the waiting flag and the pending flag are both 0, extReady is 1, irqOut is 0 and busRvalid is 0.
- R2: extReady is 1 exactly while the waiting flag is clear. A byte is captured on a rising edge where extValid and extReady are both 1.
- R3: A capture sets the waiting flag and the pending flag. irqOut equals the pending flag at all times.
- R4: A read of address 0x7D0 returns the waiting flag in bit 0, the pending flag in bit 1, and 0 in bits 31..2.
- R5: A read of address 0x7D4 returns the most recently captured byte in bits 7..0, with bits 31..8 zero. The byte does not change while the waiting flag is set.
- R6: A write to 0x7D0 with data bit 0 set clears the waiting flag. With data bit 0 clear, the waiting flag is unchanged.
- R7: A write to 0x7D0 with data bit 1 set clears the pending flag. With data bit 1 clear, the pending flag is unchanged. The two bits act independently.
- R8: If a capture and a clearing write fall on the same edge, the capture wins and the affected flag reads 1 afterwards.
- R9: A write to 0x7D4 has no effect on the flags or on the held byte, and it does not signal an error.
- R10: busGnt equals busReq in the same cycle. Each granted request gets exactly one busRvalid pulse in the following cycle, and responses come back in request order. A write response returns busRdata 0.
- R11: A request to any address other than 0x7D0 or 0x7D4 returns busErr 1 with busRdata 0. busErr is 0 for the two mapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Bus request |
| busGnt | output | 1 | Bus grant |
| busAddr | input | 32 | Byte address of the request |
| busWe | input | 1 | 1 for write, 0 for read |
| busWdata | input | 32 | Write data |
| busRvalid | output | 1 | Response valid, one cycle per request |
| busRdata | output | 32 | Response read data |
| busErr | output | 1 | Response error flag |
| extData | input | 8 | Byte from the producer |
| extValid | input | 1 | Producer has a byte |
| extReady | output | 1 | Port can take a byte |
| irqOut | output | 1 | Level interrupt, follows the pending flag |

## Verification
The two functions that can meet on one edge are a byte capture from the producer and a software write that clears the waiting or pending flag.

This collision is provoked in two ways. First, it is set up on purpose: the waiting flag is clear and the pending flag is still set, then a byte is offered in the same cycle as a write of 3 to the status word. Second, a long pseudo-random phase drives the handshake and bus traffic independently, so the collision also occurs by chance.

A behavioural model in the bench applies capture-over-clear priority. Its flags, ready, interrupt and every bus response are compared with the port's outputs on each clock.

// File: rtl/byte_rx_pkg.sv
package byte_rx_pkg;
  typedef struct packed {
    logic ackValid;
    logic clrIrq;
  } rxStrobe_t;
endpackage

// File: rtl/byte_rx_dp.sv
module byte_rx_dp
  import byte_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [DATA_W-1:0] extData,
  input  logic              extValid,
  output logic              extReady,
  output logic              validFlag,
  output logic              irqPend,
  output logic [DATA_W-1:0] heldByte
);
  logic capture;

  assign extReady = ~validFlag;
  assign capture  = extValid & ~validFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validFlag <= 1'b0;
      irqPend   <= 1'b0;
      heldByte  <= '0;
    end else begin
      if (capture) begin
        validFlag <= 1'b1;
        heldByte  <= extData;
      end else if (strobe.ackValid) begin
        validFlag <= 1'b0;
      end
      if (capture) irqPend <= 1'b1;
      else if (strobe.clrIrq) irqPend <= 1'b0;
    end
  end

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (extValid && extReady) |=> validFlag); // R3
  AST_CAPTURE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (extValid && extReady) |=> irqPend); // R3
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    validFlag |=> $stable(heldByte)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackValid && !(extValid && extReady)) |=> !validFlag); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrIrq && !(extValid && extReady)) |=> !irqPend); // R7
endmodule

// File: rtl/byte_rx_ctrl.sv
module byte_rx_ctrl
  import byte_rx_pkg::*;
#(
  parameter int          BUS_W     = 32,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] CTRL_ADDR = 32'h0000_07D0,
  parameter logic [31:0] DATA_ADDR = 32'h0000_07D4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  output logic              busGnt,
  input  logic [BUS_W-1:0]  busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic              busRvalid,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busErr,
  input  logic              validFlag,
  input  logic              irqPend,
  input  logic [DATA_W-1:0] heldByte,
  output rxStrobe_t         strobe
);
  localparam int PAD_CTRL = BUS_W - 2;
  localparam int PAD_DATA = BUS_W - DATA_W;

  logic             hitCtrl, hitData, ctrlWrite;
  logic [BUS_W-1:0] readMux;
  logic             unusedWdata;

  assign busGnt      = busReq;
  assign hitCtrl     = (busAddr == BUS_W'(CTRL_ADDR));
  assign hitData     = (busAddr == BUS_W'(DATA_ADDR));
  assign ctrlWrite   = busReq & busWe & hitCtrl;
  assign unusedWdata = ^busWdata[BUS_W-1:2];

  always_comb begin
    strobe.ackValid = ctrlWrite & busWdata[0];
    strobe.clrIrq   = ctrlWrite & busWdata[1];
    if (hitCtrl)      readMux = {{PAD_CTRL{1'b0}}, irqPend, validFlag};
    else if (hitData) readMux = {{PAD_DATA{1'b0}}, heldByte};
    else              readMux = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busErr    <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= busReq;
      busErr    <= busReq & ~(hitCtrl | hitData);
      busRdata  <= (busReq & ~busWe) ? readMux : '0;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busRvalid); // R10
  AST_NO_SPURIOUS_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busRvalid); // R10
  AST_ERR_IN_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busRvalid); // R11
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0)); // R11
endmodule

// File: rtl/byte_rx_port.sv
module byte_rx_port
  import byte_rx_pkg::*;
#(
  parameter int          BUS_W     = 32,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] CTRL_ADDR = 32'h0000_07D0,
  parameter logic [31:0] DATA_ADDR = 32'h0000_07D4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  output logic              busGnt,
  input  logic [BUS_W-1:0]  busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic              busRvalid,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busErr,
  input  logic [DATA_W-1:0] extData,
  input  logic              extValid,
  output logic              extReady,
  output logic              irqOut
);
  rxStrobe_t         strobe;
  logic              validFlag, irqPend;
  logic [DATA_W-1:0] heldByte;

  byte_rx_ctrl #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRvalid(busRvalid), .busRdata(busRdata),
    .busErr(busErr), .validFlag(validFlag), .irqPend(irqPend), .heldByte(heldByte),
    .strobe(strobe)
  );

  byte_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .extData(extData), .extValid(extValid),
    .extReady(extReady), .validFlag(validFlag), .irqPend(irqPend), .heldByte(heldByte)
  );

  assign irqOut = irqPend;

  AST_IRQ_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (extValid && extReady) |=> irqOut); // R3
endmodule

// File: tb/byte_rx_port_bench.sv
module byte_rx_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0, extValid = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [7:0]  extData = '0;
  logic        busGnt, busRvalid, busErr, extReady, irqOut;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          mValid = 0, mIrq = 0, mRv = 0, mErr = 0;
  logic [7:0]  mByte = '0;
  logic [31:0] mRdata = '0;

  byte_rx_port u_byte_rx_port (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRvalid(busRvalid), .busRdata(busRdata),
    .busErr(busErr), .extData(extData), .extValid(extValid), .extReady(extReady),
    .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, then compare away from the edge
  always @(posedge clk) begin
    if (rstN) begin
      bit cap, ack, clr, isCtrl, isData;
      logic [31:0] rd;
      cap    = extValid && !mValid;
      isCtrl = (busAddr == 32'h7D0);
      isData = (busAddr == 32'h7D4);
      ack    = busReq && busWe && isCtrl && busWdata[0];
      clr    = busReq && busWe && isCtrl && busWdata[1];
      rd = 0;
      if (busReq && !busWe && isCtrl) rd = {30'd0, mIrq, mValid};
      if (busReq && !busWe && isData) rd = {24'd0, mByte};
      mRv    = busReq;
      mErr   = busReq && !(isCtrl || isData);
      mRdata = rd;
      if (cap) begin mValid = 1; mByte = extData; end
      else if (ack) mValid = 0;
      if (cap) mIrq = 1;
      else if (clr) mIrq = 0;
      #2;
      chk("R2 extReady", {31'd0, extReady}, {31'd0, !mValid});
      chk("R3 irqOut", {31'd0, irqOut}, {31'd0, mIrq});
      chk("R10 rvalid", {31'd0, busRvalid}, {31'd0, mRv});
      if (mRv) begin
        chk("R4/R5 rdata R11", busRdata, mRdata);
        chk("R11 err", {31'd0, busErr}, {31'd0, mErr});
      end
    end
  end

  always @(negedge clk) chk("R10 gnt", {31'd0, busGnt}, {31'd0, busReq});

  task automatic cyc(input bit rq, input bit we, input logic [31:0] a, input logic [31:0] d,
                     input bit ev, input logic [7:0] ed);
    @(negedge clk);
    busReq = rq; busWe = we; busAddr = a; busWdata = d; extValid = ev; extData = ed;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, extReady}, 32'd1);
    chk("R1 irq", {31'd0, irqOut}, 32'd0);
    chk("R1 rvalid", {31'd0, busRvalid}, 32'd0);
    rstN = 1;
    // capture a byte, then offer another that must be held off (R2, R5)
    cyc(0, 0, 0, 0, 1, 8'hA5);
    cyc(0, 0, 0, 0, 1, 8'h3C);
    cyc(1, 0, 32'h7D0, 0, 1, 8'h3C);       // R4 read status
    cyc(1, 0, 32'h7D4, 0, 0, 0);           // R5 read byte
    cyc(1, 1, 32'h7D4, 32'hFF, 0, 0);      // R9 data write ignored
    cyc(1, 0, 32'h7D4, 0, 0, 0);
    cyc(1, 1, 32'h7D0, 32'h0, 0, 0);       // R6/R7 zero write no effect
    cyc(1, 1, 32'h7D0, 32'h1, 0, 0);       // R6 ack only
    cyc(1, 0, 32'h7D0, 0, 0, 0);
    // R8 collision: valid clear, irq set, byte arrives with write of 3
    cyc(1, 1, 32'h7D0, 32'h3, 1, 8'h5A);
    cyc(1, 0, 32'h7D0, 0, 0, 0);
    cyc(1, 1, 32'h7D0, 32'h2, 0, 0);       // R7 irq clear only
    cyc(1, 0, 32'h7D8, 0, 0, 0);           // R11 unmapped
    cyc(1, 1, 32'h7D1, 32'h1, 0, 0);       // R11 misaligned
    cyc(1, 0, 32'h700, 0, 0, 0);
    // pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      case ($urandom_range(0, 5))
        0, 1: a = 32'h7D0;
        2, 3: a = 32'h7D4;
        4:    a = 32'h7D8;
        default: a = 32'h7D2;
      endcase
      cyc($urandom_range(0, 9) < 5, $urandom_range(0, 1), a, $urandom,
          $urandom_range(0, 2) == 0, 8'($urandom));
    end
    cyc(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule